// File: doc/BRIEF.md
# Cascadable Serial Command Register

This block is a serial-peripheral slave designed to sit in a cascade of identical devices that share one clock line and one active-low select line. Each device's data output feeds the next device's data input. While the select line is low, every rising edge of the serial clock shifts one bit into an internal word register. The bit at the far end of that register is presented on the serial output at the following falling edge. The stream therefore leaves each device delayed by one word length and arrives at the next device in the cascade.

During one select-low period the master clocks out one command word per device, with the word for the last device sent first. When select rises, every device in the cascade copies its shift register into a parallel command register at the same time and pulses a one-cycle execute strobe. All devices therefore act together.

The three serial pins are sampled in the block's own system-clock domain through a synchronizer. Edges of the serial clock and of the select line are detected there. The command register and the strobe are driven from that same domain. The word width, the synchronizer depth and the bit order are all parameters.

Top module: `daisy_cmd_node`

## Requirements
- R1: After reset the command word is zero, the shift register holds zero, the strobe is low, and the serial output and its enable are low.
- R2: While select is low, each rising serial-clock edge shifts the data input into the shift register. With the default most-significant-first order, the first bit received ends up in bit WORD_W-1 of the word.
- R3: The serial output changes only on falling serial-clock edges while selected, or when select falls. It then shows the current far-end bit (bit WORD_W-1 by default), so the output stream equals the input stream delayed by WORD_W clocks.
- R4: Serial-clock edges and data-input activity while select is high leave the shift register and the command word unchanged.
- R5: Each rising edge of select copies the shift register into the command word and raises the execute strobe (active high) for exactly one system-clock cycle, in the same cycle the new word appears.
- R6: When the number of clocks in a select-low period is not a multiple of WORD_W, the latched word is the last WORD_W bits received, with older bits shifted out and replaced.
- R7: The shift register keeps its contents between transactions. A select-low period with no clocks presents the old far-end bit on the output and re-latches the same word with a strobe.
- R8: While select is high the serial output and its output enable are both low. While select is low the enable is high.
- R9: The command word changes only in a cycle in which the strobe is high.
- R10: In a two-device cascade, a 2×WORD_W-bit transaction delivers its first WORD_W bits to the second device and its last WORD_W bits to the first device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master; idles low |
| spi_csn | input | 1 | Active-low select shared by the whole cascade |
| spi_sdi | input | 1 | Serial data input |
| spi_sdo | output | 1 | Serial data output to the next device; low when deselected |
| spi_sdo_en | output | 1 | High while the output is driven (select low) |
| cmd_word | output | WORD_W | Latched command word |
| cmd_exec | output | 1 | One-cycle execute strobe on latching |

## Verification
A corrupted shift register appears at the serial output within one word length of clocks, because each stored bit reaches the far end and is driven out. The same fault also shows in the next device's latched word at the next select rise. A wrong command-register update shows on the command word and on the strobe count a few system-clock cycles after select rises, which is the synchronizer delay plus one register. The reference model therefore checks the serial outputs, enables and command words of two cascaded devices on every settled cycle. It also counts every strobe, so a missing, doubled or stray pulse is caught at the next transaction boundary.

// File: rtl/daisy_cmd_pkg.sv
package daisy_cmd_pkg;

   // Order in which bits of a word travel on the serial lines.
   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } bit_order_e;

   // Indices of the synchronized serial pins.
   localparam int PIN_SCLK  = 0;
   localparam int PIN_CSN   = 1;
   localparam int PIN_SDI   = 2;
   localparam int PIN_COUNT = 3;

   // Idle level of each pin, used as the synchronizer reset value.
   localparam logic [PIN_COUNT-1:0] PIN_IDLE = 3'b010;

endpackage

// File: rtl/daisy_cmd_sync.sv
module daisy_cmd_sync #(
   parameter int   STAGES    = 2,
   parameter logic IDLE_LVL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("daisy_cmd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= {STAGES{IDLE_LVL}};
         prev_q  <= IDLE_LVL;
      end else begin
         stage_q <= {stage_q[STAGES-2:0], pin};
         prev_q  <= stage_q[STAGES-1];
      end
   end

   assign level = stage_q[STAGES-1];
   assign rise  =  level & ~prev_q;
   assign fall  = ~level &  prev_q;

endmodule

// File: rtl/daisy_cmd_shifter.sv
module daisy_cmd_shifter
   import daisy_cmd_pkg::*;
#(
   parameter int         WORD_W = 16,
   parameter bit_order_e ORDER  = ORDER_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              launch_en,
   input  logic              din,
   output logic [WORD_W-1:0] word,
   output logic              dout_q
);

   localparam int TOP = WORD_W - 1;

   if (WORD_W < 2) begin : g_bad_width
      $error("daisy_cmd_shifter: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_next;
   logic              far_bit;

   if (ORDER == ORDER_MSB_FIRST) begin : g_msb_first
      assign word_next = {word_q[TOP-1:0], din};
      assign far_bit   = word_q[TOP];
   end else begin : g_lsb_first
      assign word_next = {din, word_q[TOP:1]};
      assign far_bit   = word_q[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (shift_en) begin
         word_q <= word_next;
      end
   end

   // Output bit is launched from the already-shifted word, so the
   // next device samples it on the following rising serial edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= 1'b0;
      end else if (launch_en) begin
         dout_q <= far_bit;
      end
   end

   assign word = word_q;

endmodule

// File: rtl/daisy_cmd_latch.sv
module daisy_cmd_latch #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] cmd_q,
   output logic              exec_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         exec_q <= 1'b0;
      end else begin
         exec_q <= commit;
         if (commit) begin
            cmd_q <= word_in;
         end
      end
   end

endmodule

// File: rtl/daisy_cmd_node.sv
module daisy_cmd_node
   import daisy_cmd_pkg::*;
#(
   parameter int         WORD_W      = 16,
   parameter int         SYNC_STAGES = 2,
   parameter bit_order_e BIT_ORDER   = ORDER_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_csn,
   input  logic              spi_sdi,
   output logic              spi_sdo,
   output logic              spi_sdo_en,
   output logic [WORD_W-1:0] cmd_word,
   output logic              cmd_exec
);

   logic [PIN_COUNT-1:0] pin_raw;
   logic [PIN_COUNT-1:0] pin_lvl;
   logic [PIN_COUNT-1:0] pin_rise;
   logic [PIN_COUNT-1:0] pin_fall;

   assign pin_raw[PIN_SCLK] = spi_sclk;
   assign pin_raw[PIN_CSN]  = spi_csn;
   assign pin_raw[PIN_SDI]  = spi_sdi;

   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      daisy_cmd_sync #(
         .STAGES   (SYNC_STAGES),
         .IDLE_LVL (PIN_IDLE[p])
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (pin_raw[p]),
         .level (pin_lvl[p]),
         .rise  (pin_rise[p]),
         .fall  (pin_fall[p])
      );
   end

   logic sclk_lvl_unused;
   logic sdi_edges_unused;
   assign sclk_lvl_unused  = pin_lvl[PIN_SCLK];
   assign sdi_edges_unused = pin_rise[PIN_SDI] ^ pin_fall[PIN_SDI];

   logic              csn_lvl;
   logic              csn_rise;
   logic              sclk_rise;
   logic              selected;
   logic              shift_en;
   logic              launch_en;
   logic [WORD_W-1:0] shift_word;
   logic              dout_q;

   assign csn_lvl   = pin_lvl[PIN_CSN];
   assign csn_rise  = pin_rise[PIN_CSN];
   assign sclk_rise = pin_rise[PIN_SCLK];
   assign selected  = ~csn_lvl;
   assign shift_en  = sclk_rise & selected;
   assign launch_en = (pin_fall[PIN_SCLK] & selected) | pin_fall[PIN_CSN];

   daisy_cmd_shifter #(
      .WORD_W (WORD_W),
      .ORDER  (BIT_ORDER)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (shift_en),
      .launch_en (launch_en),
      .din       (pin_lvl[PIN_SDI]),
      .word      (shift_word),
      .dout_q    (dout_q)
   );

   daisy_cmd_latch #(
      .WORD_W (WORD_W)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (csn_rise),
      .word_in (shift_word),
      .cmd_q   (cmd_word),
      .exec_q  (cmd_exec)
   );

   assign spi_sdo    = selected & dout_q;
   assign spi_sdo_en = selected;

endmodule

// File: rtl/daisy_cmd_node_chk.sv
module daisy_cmd_node_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csn_lvl,
   input logic              csn_rise,
   input logic              sclk_rise,
   input logic [WORD_W-1:0] shift_word,
   input logic              spi_sdo,
   input logic              spi_sdo_en,
   input logic [WORD_W-1:0] cmd_word,
   input logic              cmd_exec
);

   // R8: an undriven output never carries a one
   assert_sdo_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_sdo_en |-> !spi_sdo);

   // R4: deselected cycles never move the shift register
   assert_hold_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
      csn_lvl |=> $stable(shift_word));

   // R2: the shift register moves only on a serial clock rise
   assert_hold_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(shift_word));

   // R5: strobe lasts one cycle
   assert_exec_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_exec |=> !cmd_exec);

   // R5: strobe follows a select rise
   assert_exec_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_exec |-> $past(csn_rise));

   // R5: latched value is the word held when select rose
   assert_latch_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_exec |-> (cmd_word == $past(shift_word)));

   // R9: command word changes only alongside the strobe
   assert_cmd_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_word != $past(cmd_word)) |-> cmd_exec);

endmodule

bind daisy_cmd_node daisy_cmd_node_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .csn_lvl    (csn_lvl),
   .csn_rise   (csn_rise),
   .sclk_rise  (sclk_rise),
   .shift_word (shift_word),
   .spi_sdo    (spi_sdo),
   .spi_sdo_en (spi_sdo_en),
   .cmd_word   (cmd_word),
   .cmd_exec   (cmd_exec)
);

// File: tb/daisy_cmd_node_bench.sv
`timescale 1ns/1ps
module daisy_cmd_node_bench;

   localparam int W    = 16;
   localparam int HOLD = 6;
   localparam int SETTLE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic csn = 1'b1;
   logic sdi = 1'b0;

   logic         sdo0, en0, ex0, sdo1, en1, ex1;
   logic [W-1:0] cmd0, cmd1;

   always #10 clk = ~clk;

   daisy_cmd_node #(.WORD_W(W)) u_daisy_cmd_node (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_sdi(sdi),
      .spi_sdo(sdo0), .spi_sdo_en(en0), .cmd_word(cmd0), .cmd_exec(ex0));

   daisy_cmd_node #(.WORD_W(W)) u_daisy_cmd_node_next (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_sdi(sdo0),
      .spi_sdo(sdo1), .spi_sdo_en(en1), .cmd_word(cmd1), .cmd_exec(ex1));

   // Reference model: history of every bit clocked into the cascade.
   bit           hist[$];
   logic         exp_sdo0, exp_sdo1;
   logic [W-1:0] exp_cmd0, exp_cmd1;
   int           exp_pulses, seen0, seen1;
   int           since, n_checks, n_fail;
   bit           model_on, done;

   function automatic logic [W-1:0] word_at(int off);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = hist[hist.size() - 1 - off - i];
      return r;
   endfunction

   function automatic logic far_at(int off);
      return hist[hist.size() - 1 - off - (W - 1)];
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic set_pins(input logic s_clk, input logic s_csn, input logic s_di);
      @(posedge clk);
      #5;
      if (csn && !s_csn) begin
         exp_sdo0 = far_at(0);
         exp_sdo1 = far_at(W);
      end
      if (!csn && s_csn) begin
         exp_cmd0 = word_at(0);
         exp_cmd1 = word_at(W);
         exp_pulses++;
      end
      if (!csn && !s_csn && !sclk && s_clk) hist.push_back(s_di);
      if (!csn && !s_csn && sclk && !s_clk) begin
         exp_sdo0 = far_at(0);
         exp_sdo1 = far_at(W);
      end
      sclk = s_clk;
      csn  = s_csn;
      sdi  = s_di;
      since = 0;
      repeat (HOLD) @(posedge clk);
   endtask

   task automatic xfer(input logic [63:0] data, input int nbits);
      set_pins(1'b0, 1'b0, 1'b0);
      for (int i = nbits - 1; i >= 0; i--) begin
         set_pins(1'b0, 1'b0, data[i]);
         set_pins(1'b1, 1'b0, data[i]);
         set_pins(1'b0, 1'b0, data[i]);
      end
      set_pins(1'b0, 1'b1, 1'b0);
      repeat (3) @(posedge clk);
   endtask

   // Every-cycle comparison once the synchronizers have settled.
   always @(negedge clk) begin
      if (rst_n && model_on) begin
         if (ex0) seen0++;
         if (ex1) seen1++;
         if (since >= SETTLE) begin
            chk("R8", "sdo_en dev0", {31'd0, en0}, {31'd0, ~csn});
            chk("R8", "sdo_en dev1", {31'd0, en1}, {31'd0, ~csn});
            chk(csn ? "R8" : "R3", "sdo dev0", {31'd0, sdo0}, {31'd0, ~csn & exp_sdo0});
            chk(csn ? "R8" : "R3", "sdo dev1", {31'd0, sdo1}, {31'd0, ~csn & exp_sdo1});
            chk("R9", "cmd dev0", {16'd0, cmd0}, {16'd0, exp_cmd0});
            chk("R9", "cmd dev1", {16'd0, cmd1}, {16'd0, exp_cmd1});
            chk("R5", "stray exec", {30'd0, ex1, ex0}, 32'd0);
         end
         if (since < 1000) since++;
      end
   end

   task automatic pulse_check();
      chk("R5", "exec count dev0", seen0, exp_pulses);
      chk("R5", "exec count dev1", seen1, exp_pulses);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 2 * W; i++) hist.push_back(1'b0);
      exp_sdo0 = 1'b0; exp_sdo1 = 1'b0;
      exp_cmd0 = '0;   exp_cmd1 = '0;
      repeat (5) @(posedge clk);
      #5 rst_n = 1'b1;
      since = 0;
      model_on = 1'b1;
      repeat (SETTLE + 2) @(posedge clk);

      // R1: reset state
      @(negedge clk);
      chk("R1", "cmd after reset", {16'd0, cmd0}, 32'd0);
      chk("R1", "exec after reset", {31'd0, ex0}, 32'd0);
      chk("R1", "sdo/en after reset", {30'd0, en0, sdo0}, 32'd0);

      // R1/R7: select with no clocks: zero word shown, re-latched with strobe
      set_pins(1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R1", "zero far bit on select", {31'd0, sdo0}, 32'd0);
      set_pins(1'b0, 1'b1, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7", "cmd after empty select", {16'd0, cmd0}, 32'd0);
      pulse_check();

      // R2/R10: single word reaches the first device; second gets old zeros
      xfer(64'hA5C3, 16);
      @(negedge clk);
      chk("R2", "cmd dev0 single word", {16'd0, cmd0}, 32'h0000A5C3);
      chk("R10", "cmd dev1 single word", {16'd0, cmd1}, 32'd0);
      pulse_check();

      // R10/R3: two words through the cascade
      xfer(64'h1234BEEF, 32);
      @(negedge clk);
      chk("R10", "cmd dev0 cascade", {16'd0, cmd0}, 32'h0000BEEF);
      chk("R10", "cmd dev1 cascade", {16'd0, cmd1}, 32'h00001234);
      pulse_check();

      // R7: retained contents visible at the next select, no clocks
      set_pins(1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R7", "retained far bit dev0", {31'd0, sdo0}, 32'd1);
      chk("R7", "retained far bit dev1", {31'd0, sdo1}, 32'd0);
      set_pins(1'b0, 1'b1, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7", "re-latched dev0", {16'd0, cmd0}, 32'h0000BEEF);
      pulse_check();

      // R6: twenty clocks keep the last sixteen
      xfer(64'h96E1C, 20);
      @(negedge clk);
      chk("R6", "cmd dev0 20 clocks", {16'd0, cmd0}, 32'h00006E1C);
      chk("R6", "cmd dev1 20 clocks", {16'd0, cmd1}, 32'h0000EEF9);

      // R6: five clocks merge with older contents
      xfer(64'h16, 5);
      @(negedge clk);
      chk("R6", "cmd dev0 5 clocks", {16'd0, cmd0}, 32'h0000C396);
      pulse_check();

      // R4: clock and data activity while deselected is ignored
      for (int k = 0; k < 6; k++) begin
         set_pins(1'b1, 1'b1, k[0]);
         set_pins(1'b0, 1'b1, ~k[0]);
      end
      @(negedge clk);
      chk("R4", "cmd after deselected clocks", {16'd0, cmd0}, 32'h0000C396);
      set_pins(1'b0, 1'b0, 1'b0);
      set_pins(1'b0, 1'b1, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R4", "shift reg after deselected clocks", {16'd0, cmd0}, 32'h0000C396);
      pulse_check();

      done = 1'b1;
      finish_run();
   end

endmodule